// File: doc/BRIEF.md
# Masked ADC Channel Scan Controller

This block decides which analog-to-digital converter channel is converted next, starts each conversion, and times how long it lasts. Sixteen channels are enabled through two 8-bit mask registers. The controller walks the enabled channels one conversion at a time and wraps around after the last one. A conversion can be started by a manual trigger pulse when the sequencer is stopped, or by sequencer trigger pulses while the sequencer runs.

Conversion time is counted in ticks of a divided converter clock. The base is a 1 MHz tick input, and a programmable divider slows it. The duration is a fixed part of 25 ticks plus a programmable settling part. When a conversion finishes, the block captures the converter sample. It then emits a one-cycle done pulse carrying the channel tag and the result, a matching FIFO write strobe, and an optional end-of-conversion interrupt.

The channel pointer is set to the lowest enabled channel the first time the sequencer starts. It keeps its position when the sequencer is stopped and started again. It is realigned to the lowest enabled channel whenever a mask is written while the sequencer is stopped.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, chan_idx is 0, and busy, done, fifo_wr, irq_eoc, trig_err and first_chan are all 0. The settling count resets to 64.
- R2: Channel i for i in 0..7 is enabled by bit i of the low mask, and channel i for i in 8..15 by bit i-8 of the high mask. Successive conversions visit the enabled channels in ascending index and wrap from the highest enabled index back to the lowest.
- R3: A completed conversion gives one cycle with done and fifo_wr high. In that cycle done_chan is the converted channel, and done_data is adc_sample as it stood in the cycle before the pulse. In the same step chan_idx advances to the next enabled channel.
- R4: A write to either mask while seq_run is 0 sets chan_idx to the lowest channel enabled by the new masks, or to 0 when none is enabled.
- R5: The first rising edge of seq_run after reset sets chan_idx to the lowest enabled channel.
- R6: Later rising edges of seq_run leave chan_idx unchanged, and mask writes while seq_run is 1 leave chan_idx unchanged. If the pointed channel has been disabled, the next start converts the next enabled channel after it.
- R7: Busy rises one cycle after the start edge. With clk_en_1m held high, done appears (25 + settle) * (div_cfg + 1) clock cycles after the start edge. A write on settle_wr loads the settling count.
- R8: irq_eoc pulses together with done when irq_en is 1, and stays 0 when irq_en is 0.
- R9: A trigger that arrives while busy is 1 starts nothing and sets trig_err, which stays 1 until reset.
- R10: When both masks are 0, triggers start no conversion and do not set trig_err.
- R11: While seq_run is 1 only seq_trig starts conversions and manual_start is ignored. While seq_run is 0 only manual_start starts conversions.
- R12: first_chan is 1 exactly when at least one channel is enabled and chan_idx equals the lowest enabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en_1m | input | 1 | 1 MHz base tick of the converter clock |
| div_cfg | input | 8 | Divider: one converter tick per div_cfg+1 base ticks |
| mask_lo_wr | input | 1 | Write strobe for the low channel mask |
| mask_hi_wr | input | 1 | Write strobe for the high channel mask |
| settle_wr | input | 1 | Write strobe for the settling count |
| cfg_wdata | input | 8 | Data for the three configuration writes |
| manual_start | input | 1 | Manual conversion trigger (sequencer stopped) |
| seq_run | input | 1 | Sequencer running level |
| seq_trig | input | 1 | Sequencer conversion trigger pulse |
| irq_en | input | 1 | Enables the end-of-conversion interrupt |
| adc_sample | input | 14 | Converter result, captured at completion |
| chan_idx | output | 4 | Current channel pointer |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| done_chan | output | 4 | Channel tag of the completed conversion |
| done_data | output | 14 | Captured result |
| fifo_wr | output | 1 | Sample write strobe toward the FIFO |
| irq_eoc | output | 1 | End-of-conversion interrupt pulse |
| trig_err | output | 1 | Sticky flag: a trigger arrived while busy |
| first_chan | output | 1 | Pointer is on the lowest enabled channel |

## Verification
The scan is run with a sparse two-mask pattern of channels 0, 2, 8 and 15. This pattern shows whether the walk crosses from the low to the high mask in index order and wraps back to channel 0. A second pattern, channels 1 and 2 only, is converted under the sequencer. It shows the difference between the first sequencer start, a restart, and a mask write made while running. Conversion lengths are measured for the default settling count and for a short count with a divide of three. This tells a wrong fixed part apart from a wrong divider. Triggers sent on the inactive source, during a busy conversion, and with empty masks check that each of these is rejected for its own reason.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   localparam int unsigned CONV_BASE_CYC = 25;
   localparam int unsigned SETTLE_RESET  = 64;
   typedef enum logic {
      MODE_MANUAL = 1'b0,
      MODE_SEQ    = 1'b1
   } scan_mode_e;
endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
   parameter int CFG_W   = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             base_tick,
   input  logic [CFG_W-1:0] div_cfg,
   output logic             conv_tick
);
   generate
      if (HAS_DIV) begin : g_div
         logic [CFG_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (restart)
               cnt_q <= '0;
            else if (base_tick)
               cnt_q <= (cnt_q == div_cfg) ? '0 : cnt_q + 1'b1;
         end
         assign conv_tick = base_tick && !restart && (cnt_q == div_cfg);

         // R7
         tick_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_tick && div_cfg != '0 && $stable(div_cfg)) |=> !conv_tick);
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^{div_cfg, restart, clk, rst_n};
         assign conv_tick  = base_tick;
      end
   endgenerate
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic [LEN_W-1:0] len,
   output logic             busy,
   output logic             finish
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             busy_q;

   assign finish = busy_q && tick && (cnt_q == len_q - 1'b1);
   assign busy   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         len_q  <= len;
      end else if (finish) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R3
   finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !busy);
endmodule

// File: rtl/adc_chan_ptr.sv
module adc_chan_ptr #(
   parameter int MASK_W = 8,
   localparam int NCH   = 2 * MASK_W,
   localparam int IDX_W = $clog2(NCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   en_cur,
   input  logic [NCH-1:0]   en_nxt,
   input  logic             mask_wr,
   input  logic             seq_mode,
   input  logic             seq_rise,
   input  logic             advance,
   input  logic [IDX_W-1:0] adv_from,
   output logic [IDX_W-1:0] ptr,
   output logic [IDX_W-1:0] eff_chan,
   output logic             first_hit
);
   function automatic logic [IDX_W-1:0] scan_from(input logic [NCH-1:0] e,
                                                  input logic [IDX_W-1:0] base,
                                                  input logic skip);
      logic [IDX_W-1:0] r;
      logic [IDX_W-1:0] c;
      logic             hit;
      r   = '0;
      hit = 1'b0;
      for (int k = 0; k < NCH; k++) begin
         c = IDX_W'(int'(base) + k + int'(skip));
         if (!hit && e[c]) begin
            r   = c;
            hit = 1'b1;
         end
      end
      return r;
   endfunction

   logic [IDX_W-1:0] ptr_q;
   logic             seq_seen_q;
   logic [IDX_W-1:0] lowest_cur;
   logic [IDX_W-1:0] lowest_nxt;

   assign lowest_cur = scan_from(en_cur, '0, 1'b0);
   assign lowest_nxt = scan_from(en_nxt, '0, 1'b0);
   assign eff_chan   = scan_from(en_cur, ptr_q, 1'b0);
   assign first_hit  = (|en_cur) && (ptr_q == lowest_cur);
   assign ptr        = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         seq_seen_q <= 1'b0;
      end else begin
         if (seq_rise)
            seq_seen_q <= 1'b1;
         if (mask_wr && !seq_mode)
            ptr_q <= lowest_nxt;
         else if (seq_rise && !seq_seen_q)
            ptr_q <= lowest_cur;
         else if (advance)
            ptr_q <= scan_from(en_cur, adv_from, 1'b1);
      end
   end

   // R4
   manual_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && !seq_mode) |=> (ptr == $past(lowest_nxt)));
   // R6
   seq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_rise && seq_seen_q && !mask_wr && !advance) |=> $stable(ptr));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
   parameter int MASK_W  = 8,
   parameter int CFG_W   = 8,
   parameter int DATA_W  = 14,
   parameter bit HAS_DIV = 1'b1,
   localparam int NCH    = 2 * MASK_W,
   localparam int IDX_W  = $clog2(NCH),
   localparam int LEN_W  = CFG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_1m,
   input  logic [CFG_W-1:0]  div_cfg,
   input  logic              mask_lo_wr,
   input  logic              mask_hi_wr,
   input  logic              settle_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              manual_start,
   input  logic              seq_run,
   input  logic              seq_trig,
   input  logic              irq_en,
   input  logic [DATA_W-1:0] adc_sample,
   output logic [IDX_W-1:0]  chan_idx,
   output logic              busy,
   output logic              done,
   output logic [IDX_W-1:0]  done_chan,
   output logic [DATA_W-1:0] done_data,
   output logic              fifo_wr,
   output logic              irq_eoc,
   output logic              trig_err,
   output logic              first_chan
);
   import adc_scan_pkg::*;

   if (NCH != (1 << IDX_W)) begin : g_bad_nch
      $error("adc_scan_ctrl: 2*MASK_W must be a power of two");
   end
   if (MASK_W > CFG_W) begin : g_bad_mask
      $error("adc_scan_ctrl: MASK_W must not exceed CFG_W");
   end
   if (CONV_BASE_CYC + (1 << CFG_W) > (1 << LEN_W)) begin : g_bad_len
      $error("adc_scan_ctrl: conversion length does not fit its counter");
   end

   logic [MASK_W-1:0] mask_lo_q, mask_hi_q;
   logic [CFG_W-1:0]  settle_q;
   logic [NCH-1:0]    en_cur, en_nxt;
   logic              seq_run_q, seq_rise, mask_wr;
   scan_mode_e        mode;
   logic              start_req, start_go, conv_tick, finish;
   logic [IDX_W-1:0]  eff_chan, conv_chan_q;
   logic [LEN_W-1:0]  conv_len;
   logic              done_q, irq_q, err_q;
   logic [IDX_W-1:0]  done_chan_q;
   logic [DATA_W-1:0] done_data_q;

   assign mode      = seq_run ? MODE_SEQ : MODE_MANUAL;
   assign en_cur    = {mask_hi_q, mask_lo_q};
   assign en_nxt    = {mask_hi_wr ? cfg_wdata[MASK_W-1:0] : mask_hi_q,
                       mask_lo_wr ? cfg_wdata[MASK_W-1:0] : mask_lo_q};
   assign mask_wr   = mask_lo_wr | mask_hi_wr;
   assign seq_rise  = seq_run && !seq_run_q;
   assign start_req = (mode == MODE_SEQ) ? seq_trig : manual_start;
   assign start_go  = start_req && !busy && (|en_cur);
   assign conv_len  = LEN_W'(CONV_BASE_CYC) + LEN_W'(settle_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_lo_q   <= '0;
         mask_hi_q   <= '0;
         settle_q    <= CFG_W'(SETTLE_RESET);
         seq_run_q   <= 1'b0;
         conv_chan_q <= '0;
         done_q      <= 1'b0;
         irq_q       <= 1'b0;
         err_q       <= 1'b0;
         done_chan_q <= '0;
         done_data_q <= '0;
      end else begin
         if (mask_lo_wr) mask_lo_q <= cfg_wdata[MASK_W-1:0];
         if (mask_hi_wr) mask_hi_q <= cfg_wdata[MASK_W-1:0];
         if (settle_wr)  settle_q  <= cfg_wdata;
         seq_run_q <= seq_run;
         if (start_go) conv_chan_q <= eff_chan;
         if (start_req && busy) err_q <= 1'b1;
         done_q <= finish;
         irq_q  <= finish && irq_en;
         if (finish) begin
            done_chan_q <= conv_chan_q;
            done_data_q <= adc_sample;
         end
      end
   end

   adc_tick_div #(.CFG_W(CFG_W), .HAS_DIV(HAS_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(start_go), .base_tick(clk_en_1m),
      .div_cfg(div_cfg), .conv_tick(conv_tick));

   adc_conv_timer #(.LEN_W(LEN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_go), .tick(conv_tick),
      .len(conv_len), .busy(busy), .finish(finish));

   adc_chan_ptr #(.MASK_W(MASK_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .en_cur(en_cur), .en_nxt(en_nxt),
      .mask_wr(mask_wr), .seq_mode(mode == MODE_SEQ), .seq_rise(seq_rise),
      .advance(finish), .adv_from(conv_chan_q), .ptr(chan_idx),
      .eff_chan(eff_chan), .first_hit(first_chan));

   assign done      = done_q;
   assign fifo_wr   = done_q;
   assign done_chan = done_chan_q;
   assign done_data = done_data_q;
   assign irq_eoc   = irq_q;
   assign trig_err  = err_q;

   // R9
   busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_req) |=> trig_err);
   // R10
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && en_cur == '0) |=> !busy);
   // R8
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_eoc |-> done);
   // R11
   src_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_run && !seq_trig && !busy) |=> !busy);
   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en_1m = 1'b1;
   logic [7:0]  div_cfg = '0;
   logic        mask_lo_wr = 1'b0, mask_hi_wr = 1'b0, settle_wr = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic        manual_start = 1'b0, seq_run = 1'b0, seq_trig = 1'b0;
   logic        irq_en = 1'b1;
   logic [13:0] adc_sample = '0;
   logic [3:0]  chan_idx, done_chan;
   logic [13:0] done_data;
   logic        busy, done, fifo_wr, irq_eoc, trig_err, first_chan;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   adc_scan_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .clk_en_1m(clk_en_1m), .div_cfg(div_cfg),
      .mask_lo_wr(mask_lo_wr), .mask_hi_wr(mask_hi_wr), .settle_wr(settle_wr),
      .cfg_wdata(cfg_wdata), .manual_start(manual_start), .seq_run(seq_run),
      .seq_trig(seq_trig), .irq_en(irq_en), .adc_sample(adc_sample),
      .chan_idx(chan_idx), .busy(busy), .done(done), .done_chan(done_chan),
      .done_data(done_data), .fifo_wr(fifo_wr), .irq_eoc(irq_eoc),
      .trig_err(trig_err), .first_chan(first_chan));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic cfg_write(input int which, input logic [7:0] d);
      @(negedge clk);
      cfg_wdata = d;
      if (which == 0) mask_lo_wr = 1'b1;
      else if (which == 1) mask_hi_wr = 1'b1;
      else settle_wr = 1'b1;
      @(negedge clk);
      mask_lo_wr = 1'b0; mask_hi_wr = 1'b0; settle_wr = 1'b0;
   endtask

   // Runs one conversion and checks tag, data, strobes, irq, length and next pointer
   task automatic do_conv(input bit use_seq, input int exp_chan, input logic [13:0] smp,
                          input int exp_len, input int exp_next, input string req);
      int k;
      bit irq_early;
      @(negedge clk);
      adc_sample = smp;
      if (use_seq) seq_trig = 1'b1; else manual_start = 1'b1;
      @(negedge clk);
      seq_trig = 1'b0; manual_start = 1'b0;
      chk(busy == 1'b1, {req, " busy after start"}, int'(busy), 1);
      k = 0;
      irq_early = 1'b0;
      while (!done && k < 5000) begin
         @(negedge clk);
         k++;
         if (irq_eoc && !done) irq_early = 1'b1;
      end
      chk(done == 1'b1, {req, " done seen"}, int'(done), 1);
      chk(done_chan == 4'(exp_chan), {req, " R2 done_chan"}, int'(done_chan), exp_chan);
      chk(done_data == smp, {req, " R3 done_data"}, int'(done_data), int'(smp));
      chk(fifo_wr == 1'b1, {req, " R3 fifo_wr"}, int'(fifo_wr), 1);
      chk(irq_eoc == irq_en && !irq_early, {req, " R8 irq_eoc"}, int'(irq_eoc), int'(irq_en));
      if (exp_len > 0)
         chk(k == exp_len, {req, " R7 length"}, k, exp_len);
      @(negedge clk);
      chk(!done && !fifo_wr, {req, " R3 single pulse"}, int'(done), 0);
      chk(chan_idx == 4'(exp_next), {req, " R3 next pointer"}, int'(chan_idx), exp_next);
   endtask

   task automatic expect_no_start(input string req);
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (busy || done) seen = 1'b1;
      end
      chk(!seen, req, int'(seen), 0);
   endtask

   task automatic t_reset();
      chk(chan_idx == 0, "R1 chan_idx", int'(chan_idx), 0);
      chk(!busy && !done && !fifo_wr && !irq_eoc, "R1 outputs idle", int'(busy), 0);
      chk(!trig_err, "R1 trig_err", int'(trig_err), 0);
      chk(!first_chan, "R1 first_chan", int'(first_chan), 0);
   endtask

   task automatic t_empty();
      @(negedge clk); manual_start = 1'b1;
      @(negedge clk); manual_start = 1'b0;
      expect_no_start("R10 empty mask start");
      chk(!trig_err, "R10 no error", int'(trig_err), 0);
   endtask

   task automatic t_scan();
      cfg_write(0, 8'h05);
      cfg_write(1, 8'h81);
      chk(chan_idx == 0, "R4 realign after write", int'(chan_idx), 0);
      chk(first_chan, "R12 first_chan on lowest", int'(first_chan), 1);
      do_conv(1'b0, 0, 14'h1234, 89, 2, "R1 R7 default settle");
      chk(!first_chan, "R12 first_chan off", int'(first_chan), 0);
      do_conv(1'b0, 2, 14'h0abc, 0, 8, "R2 low mask");
      do_conv(1'b0, 8, 14'h3fff, 0, 15, "R2 high mask");
      do_conv(1'b0, 15, 14'h0001, 0, 0, "R2 wrap");
   endtask

   task automatic t_irq_off();
      irq_en = 1'b0;
      do_conv(1'b0, 0, 14'h2222, 0, 2, "R8 irq disabled");
      irq_en = 1'b1;
   endtask

   task automatic t_src();
      @(negedge clk); seq_trig = 1'b1;
      @(negedge clk); seq_trig = 1'b0;
      expect_no_start("R11 seq_trig ignored in manual mode");
      chk(chan_idx == 2, "R11 pointer kept", int'(chan_idx), 2);
   endtask

   task automatic t_timing();
      cfg_write(2, 8'd3);
      div_cfg = 8'd2;
      do_conv(1'b0, 2, 14'h0555, 84, 8, "R7 settle 3 div 3");
      div_cfg = 8'd0;
      do_conv(1'b0, 8, 14'h0aaa, 28, 15, "R7 settle 3 div 1");
   endtask

   task automatic t_busy();
      int dones;
      @(negedge clk); adc_sample = 14'h0777; manual_start = 1'b1;
      @(negedge clk); manual_start = 1'b0;
      for (int i = 0; i < 10; i++) @(negedge clk);
      manual_start = 1'b1;
      @(negedge clk); manual_start = 1'b0;
      chk(trig_err, "R9 trig_err set", int'(trig_err), 1);
      dones = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (done) begin
            dones++;
            chk(done_chan == 15, "R9 tag of first conversion", int'(done_chan), 15);
         end
      end
      chk(dones == 1, "R9 only one conversion", dones, 1);
      chk(!busy, "R9 idle after", int'(busy), 0);
      chk(trig_err, "R9 trig_err sticky", int'(trig_err), 1);
      chk(chan_idx == 0, "R9 pointer one step", int'(chan_idx), 0);
   endtask

   task automatic t_manual_realign();
      do_conv(1'b0, 0, 14'h0100, 0, 2, "R2 before realign");
      cfg_write(1, 8'h81);
      chk(chan_idx == 0, "R4 realign mid scan", int'(chan_idx), 0);
   endtask

   task automatic t_seq();
      cfg_write(0, 8'h06);
      cfg_write(1, 8'h00);
      chk(chan_idx == 1, "R4 realign to ch1", int'(chan_idx), 1);
      do_conv(1'b0, 1, 14'h0011, 0, 2, "R4 manual ch1");
      @(negedge clk); seq_run = 1'b1;
      @(negedge clk);
      chk(chan_idx == 1, "R5 first start to lowest", int'(chan_idx), 1);
      chk(first_chan, "R12 first_chan after start", int'(first_chan), 1);
      @(negedge clk); manual_start = 1'b1;
      @(negedge clk); manual_start = 1'b0;
      expect_no_start("R11 manual_start ignored in sequencer mode");
      do_conv(1'b1, 1, 14'h0022, 0, 2, "R11 seq trig ch1");
      @(negedge clk); seq_run = 1'b0;
      @(negedge clk); seq_run = 1'b1;
      @(negedge clk);
      chk(chan_idx == 2, "R6 restart keeps pointer", int'(chan_idx), 2);
      cfg_write(1, 8'h01);
      chk(chan_idx == 2, "R6 mask write in seq mode", int'(chan_idx), 2);
      do_conv(1'b1, 2, 14'h0033, 0, 8, "R6 continue ch2");
      chk(!first_chan, "R12 not on lowest", int'(first_chan), 0);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_empty();
      t_scan();
      t_irq_off();
      t_src();
      t_timing();
      t_busy();
      t_manual_realign();
      t_seq();
      finish_run();
   end
endmodule